// File: doc/BRIEF.md
# Ordered Speculative Store Buffers with Visibility-Filtered Line Merge

This block sits in front of a shared second-level cache and gives each of four speculative threads a private store buffer. A store from a speculative thread is held in that thread's buffer at byte granularity. It stays out of the shared cache until the thread commits. The thread slots form a ring. The slot at `head_slot` runs the least speculative thread, and each step around the ring from it holds a younger thread.

When a first-level cache misses, the requester asks for a line. The block reads the line from the shared cache and overlays on it the bytes held by the requester and by every older thread, with younger visible threads winning. Bytes held by threads younger than the requester are never visible to it. A commit of the head thread drains its buffer into the shared cache. The slot then becomes the youngest thread. An abort of a speculative thread throws its buffer away. The head thread cannot be violated, so its stores go straight into the shared cache.

The drain sequencer is a three-state machine. IDLE waits for a commit. A commit moves it IDLE→DRAIN. DRAIN visits one buffer entry per cycle and moves DRAIN→DONE after the last entry. DONE pulses `drain_done`, empties the buffer and advances the head, then moves DONE→IDLE.

Top module: `spec_wb_top`

## Requirements
- R1: After reset all buffers are empty, `head_slot` is 0, `st_stall` and `drain_done` are low, `rd_rvalid` is low, and every shared-cache line reads as zero.
- R2: A store accepted from a non-head slot leaves the shared cache unchanged. It is visible only to that slot and to younger slots until the slot commits.
- R3: A read returns, for each byte, the value from the youngest slot that holds that byte and is no younger than the requester. If no such slot holds the byte, the read returns the shared-cache byte. Byte b of the line is `rd_rdata[8b+7:8b]`. Age is (slot − head_slot) mod 4.
- R4: A read never returns a byte held only by a slot younger than the requester.
- R5: A commit in IDLE drains the head buffer's masked bytes into the shared cache. `drain_done` goes high exactly 9 cycles after the commit edge (8 entries plus one), for one cycle. On the following edge `head_slot` advances by one modulo 4 and that buffer is empty.
- R6: An abort of a non-head slot empties its buffer and leaves the shared cache unchanged. An abort naming the head slot is ignored.
- R7: A store from a non-head slot stalls (`st_stall` high, store not taken) when the slot holds 8 distinct lines and the store's line is not among them. A store to a line already held is accepted.
- R8: A store from the head slot while IDLE never stalls and is written into the shared cache at once.
- R9: `rd_rvalid` is high exactly one cycle after `rd_valid`. `rd_rdata` carries the merged line as of the request cycle.
- R10: A store places `st_data[8i+7:8i]` at line byte `8*st_word+i` for each set `st_be[i]`. Unset lanes keep their previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_slot | input | 2 | Issuing thread slot |
| st_line | input | 4 | Line index |
| st_word | input | 2 | 64-bit word within the line |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Byte enables |
| st_stall | output | 1 | Store not taken this cycle |
| rd_valid | input | 1 | Line read request (first-level miss) |
| rd_slot | input | 2 | Requesting thread slot |
| rd_line | input | 4 | Line index |
| rd_rvalid | output | 1 | Read data valid |
| rd_rdata | output | 256 | Merged line |
| cmt_valid | input | 1 | Head thread commits |
| abort_valid | input | 1 | Discard a thread's buffer |
| abort_slot | input | 2 | Slot to discard |
| drain_done | output | 1 | Head buffer fully drained (one-cycle pulse) |
| head_slot | output | 2 | Slot of the least speculative thread |

## Verification
The hardest case to reach from the ports is a full buffer in a slot that is not the head. It takes eight stores to distinct lines from a single younger slot, with no commit or abort of that slot in between. The stimulus first aborts the slot to make its occupancy known, then fills it, and then offers a ninth line. Next it commits the head so that the stalled slot becomes least speculative, and the same store must then pass straight through. The merge rules are covered by several rounds of stores with pseudo-random slots, words and byte enables over a few lines. Each round is followed by reads of every line from every slot, checked against a byte-level model of the buffers and the cache.

// File: rtl/spec_wb_pkg.sv
package spec_wb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_DONE
    } drain_st_t;

    // Distance of a slot from the head: 0 = least speculative.
    function automatic int slot_age(int slot, int head, int n);
        return (slot - head + n) % n;
    endfunction

endpackage

// File: rtl/spec_wb_buf.sv
module spec_wb_buf #(
    parameter int NENT   = 8,
    parameter int LBYTES = 32,
    parameter int WBYTES = 8,
    parameter int LW     = 4,
    localparam int EW    = $clog2(NENT),
    localparam int WSW   = $clog2(LBYTES / WBYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                wr_en,
    input  logic                wr_alloc,
    input  logic [LW-1:0]       wr_line,
    input  logic [WSW-1:0]      wr_word,
    input  logic [WBYTES*8-1:0] wr_data,
    input  logic [WBYTES-1:0]   wr_be,
    output logic                full_miss,
    input  logic [LW-1:0]       rd_line,
    output logic                rd_hit,
    output logic [LBYTES*8-1:0] rd_data,
    output logic [LBYTES-1:0]   rd_mask,
    input  logic [EW-1:0]       dr_idx,
    output logic [LW-1:0]       dr_tag,
    output logic [LBYTES*8-1:0] dr_data,
    output logic [LBYTES-1:0]   dr_mask
);

    logic [LW-1:0]       tag_q [NENT];
    logic [LBYTES*8-1:0] dat_q [NENT];
    logic [LBYTES-1:0]   msk_q [NENT];
    logic [NENT-1:0]     used;
    logic                wr_hit, have_free;
    logic [EW-1:0]       hit_idx, free_idx, rd_idx;

    always_comb begin
        wr_hit    = 1'b0;
        have_free = 1'b0;
        rd_hit    = 1'b0;
        hit_idx   = '0;
        free_idx  = '0;
        rd_idx    = '0;
        for (int e = 0; e < NENT; e++) begin
            used[e] = |msk_q[e];
            if (used[e] && tag_q[e] == wr_line && !wr_hit) begin
                wr_hit  = 1'b1;
                hit_idx = EW'(e);
            end
            if (!used[e] && !have_free) begin
                have_free = 1'b1;
                free_idx  = EW'(e);
            end
            if (used[e] && tag_q[e] == rd_line && !rd_hit) begin
                rd_hit = 1'b1;
                rd_idx = EW'(e);
            end
        end
    end

    assign full_miss = !wr_hit && !have_free;
    assign rd_data   = dat_q[rd_idx];
    assign rd_mask   = rd_hit ? msk_q[rd_idx] : '0;
    assign dr_tag    = tag_q[dr_idx];
    assign dr_data   = dat_q[dr_idx];
    assign dr_mask   = msk_q[dr_idx];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int e = 0; e < NENT; e++) begin
                msk_q[e] <= '0;
                tag_q[e] <= '0;
                dat_q[e] <= '0;
            end
        end else if (wr_en && (wr_hit || (wr_alloc && have_free))) begin
            if (!wr_hit) begin
                tag_q[free_idx] <= wr_line;
                msk_q[free_idx] <= '0;
            end
            for (int b = 0; b < WBYTES; b++) begin
                if (wr_be[b]) begin
                    dat_q[wr_hit ? hit_idx : free_idx][(int'(wr_word) * WBYTES + b) * 8 +: 8] <= wr_data[b*8 +: 8];
                    msk_q[wr_hit ? hit_idx : free_idx][int'(wr_word) * WBYTES + b] <= 1'b1;
                end
            end
        end
    end

    // R6
    buf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (used == '0));

    // R7
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_alloc) |-> (wr_hit || have_free));

endmodule

// File: rtl/spec_wb_merge.sv
module spec_wb_merge #(
    parameter int NTHR   = 4,
    parameter int LBYTES = 32,
    localparam int TW    = $clog2(NTHR)
) (
    input  logic [TW-1:0]       head,
    input  logic [TW-1:0]       req_slot,
    input  logic [LBYTES*8-1:0] base,
    input  logic [NTHR-1:0]     hit,
    input  logic [LBYTES*8-1:0] data [NTHR],
    input  logic [LBYTES-1:0]   mask [NTHR],
    output logic [LBYTES*8-1:0] merged
);
    import spec_wb_pkg::*;

    int req_age;

    // Walk from oldest to requester; later (younger) writers override.
    always_comb begin
        req_age = slot_age(int'(req_slot), int'(head), NTHR);
        merged  = base;
        for (int k = 0; k < NTHR; k++) begin
            if (k <= req_age && hit[(int'(head) + k) % NTHR]) begin
                for (int b = 0; b < LBYTES; b++) begin
                    if (mask[(int'(head) + k) % NTHR][b])
                        merged[b*8 +: 8] = data[(int'(head) + k) % NTHR][b*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/spec_wb_drain.sv
module spec_wb_drain #(
    parameter int NTHR = 4,
    parameter int NENT = 8,
    localparam int TW  = $clog2(NTHR),
    localparam int EW  = $clog2(NENT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    output logic [TW-1:0] head,
    output logic [EW-1:0] dr_idx,
    output logic          dr_active,
    output logic          busy,
    output logic          done
);
    import spec_wb_pkg::*;

    drain_st_t     state_q, state_d;
    logic [EW-1:0] cnt_q;
    logic [TW-1:0] head_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            head_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_DRAIN) ? cnt_q + 1'b1 : '0;
            if (state_q == ST_DONE)
                head_q <= (head_q == TW'(NTHR - 1)) ? '0 : head_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (commit) state_d = ST_DRAIN;
            ST_DRAIN: if (cnt_q == EW'(NENT - 1)) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        head      = head_q;
        dr_idx    = cnt_q;
        dr_active = (state_q == ST_DRAIN);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
    end

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q != $past(head_q)) |-> $past(done));

endmodule

// File: rtl/spec_wb_top.sv
module spec_wb_top #(
    parameter int NTHR    = 4,
    parameter int NENT    = 8,
    parameter int LBYTES  = 32,
    parameter int WBYTES  = 8,
    parameter int NLINES  = 16,
    localparam int TW     = $clog2(NTHR),
    localparam int LW     = $clog2(NLINES),
    localparam int WSW    = $clog2(LBYTES / WBYTES),
    localparam int EW     = $clog2(NENT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    input  logic [TW-1:0]       st_slot,
    input  logic [LW-1:0]       st_line,
    input  logic [WSW-1:0]      st_word,
    input  logic [WBYTES*8-1:0] st_data,
    input  logic [WBYTES-1:0]   st_be,
    output logic                st_stall,
    input  logic                rd_valid,
    input  logic [TW-1:0]       rd_slot,
    input  logic [LW-1:0]       rd_line,
    output logic                rd_rvalid,
    output logic [LBYTES*8-1:0] rd_rdata,
    input  logic                cmt_valid,
    input  logic                abort_valid,
    input  logic [TW-1:0]       abort_slot,
    output logic                drain_done,
    output logic [TW-1:0]       head_slot
);

    logic [LBYTES*8-1:0] mem_q [NLINES];
    logic [TW-1:0]       head;
    logic [EW-1:0]       dr_idx;
    logic                dr_active, busy, done;

    logic [NTHR-1:0]     full_miss, rd_hit;
    logic [LBYTES*8-1:0] rd_data_a [NTHR];
    logic [LBYTES-1:0]   rd_mask_a [NTHR];
    logic [LW-1:0]       dr_tag_a  [NTHR];
    logic [LBYTES*8-1:0] dr_data_a [NTHR];
    logic [LBYTES-1:0]   dr_mask_a [NTHR];
    logic [LBYTES*8-1:0] merged;
    logic                st_is_head, st_take, wt_fire;

    spec_wb_drain #(.NTHR(NTHR), .NENT(NENT)) u_drain (
        .clk(clk), .rst_n(rst_n), .commit(cmt_valid), .head(head),
        .dr_idx(dr_idx), .dr_active(dr_active), .busy(busy), .done(done)
    );

    assign st_is_head = (st_slot == head);
    assign st_stall   = st_valid && (st_is_head ? busy : full_miss[st_slot]);
    assign st_take    = st_valid && !st_stall;
    assign wt_fire    = st_take && st_is_head;

    for (genvar t = 0; t < NTHR; t++) begin : g_buf
        spec_wb_buf #(.NENT(NENT), .LBYTES(LBYTES), .WBYTES(WBYTES), .LW(LW)) u_buf (
            .clk(clk), .rst_n(rst_n),
            .clr((abort_valid && abort_slot == TW'(t) && head != TW'(t)) || (done && head == TW'(t))),
            .wr_en(st_take && st_slot == TW'(t)),
            .wr_alloc(!st_is_head),
            .wr_line(st_line), .wr_word(st_word), .wr_data(st_data), .wr_be(st_be),
            .full_miss(full_miss[t]),
            .rd_line(rd_line), .rd_hit(rd_hit[t]), .rd_data(rd_data_a[t]), .rd_mask(rd_mask_a[t]),
            .dr_idx(dr_idx), .dr_tag(dr_tag_a[t]), .dr_data(dr_data_a[t]), .dr_mask(dr_mask_a[t])
        );
    end

    spec_wb_merge #(.NTHR(NTHR), .LBYTES(LBYTES)) u_merge (
        .head(head), .req_slot(rd_slot), .base(mem_q[rd_line]),
        .hit(rd_hit), .data(rd_data_a), .mask(rd_mask_a), .merged(merged)
    );

    // Shared cache: drain of head entries and head write-through never coincide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < NLINES; l++) mem_q[l] <= '0;
        end else if (dr_active) begin
            for (int b = 0; b < LBYTES; b++)
                if (dr_mask_a[head][b])
                    mem_q[dr_tag_a[head]][b*8 +: 8] <= dr_data_a[head][b*8 +: 8];
        end else if (wt_fire) begin
            for (int b = 0; b < WBYTES; b++)
                if (st_be[b])
                    mem_q[st_line][(int'(st_word) * WBYTES + b) * 8 +: 8] <= st_data[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_rvalid <= 1'b0;
            rd_rdata  <= '0;
        end else begin
            rd_rvalid <= rd_valid;
            if (rd_valid) rd_rdata <= merged;
        end
    end

    assign drain_done = done;
    assign head_slot  = head;

    // R8
    head_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_slot == head_slot && !busy) |-> !st_stall);

    // R9
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_rvalid);

    // R9
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !rd_rvalid);

endmodule

// File: tb/tb_spec_wb_top.sv
module tb_spec_wb_top;

    localparam int NT = 4, NE = 8, LB = 32, WB = 8, NL = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 0, rd_valid = 0, cmt_valid = 0, abort_valid = 0;
    logic [1:0] st_slot = 0, st_word = 0, rd_slot = 0, abort_slot = 0;
    logic [3:0] st_line = 0, rd_line = 0;
    logic [63:0] st_data = 0;
    logic [7:0] st_be = 0;
    logic st_stall, rd_rvalid, drain_done;
    logic [255:0] rd_rdata;
    logic [1:0] head_slot;

    always #2.5 clk = ~clk;

    spec_wb_top dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_slot(st_slot), .st_line(st_line),
        .st_word(st_word), .st_data(st_data), .st_be(st_be), .st_stall(st_stall),
        .rd_valid(rd_valid), .rd_slot(rd_slot), .rd_line(rd_line), .rd_rvalid(rd_rvalid),
        .rd_rdata(rd_rdata), .cmt_valid(cmt_valid), .abort_valid(abort_valid),
        .abort_slot(abort_slot), .drain_done(drain_done), .head_slot(head_slot)
    );

    int errs = 0, checks = 0;
    logic [7:0] mem_m [NL][LB];
    logic [7:0] sv [NT][NL][LB];
    bit         sm [NT][NL][LB];
    int         head_m = 0;
    logic [31:0] lf = 32'h1234_5677;

    task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
        return y;
    endfunction

    function automatic bit line_held(int s, int l);
        for (int b = 0; b < LB; b++) if (sm[s][l][b]) return 1;
        return 0;
    endfunction

    function automatic int lines_held(int s);
        int n = 0;
        for (int l = 0; l < NL; l++) if (line_held(s, l)) n++;
        return n;
    endfunction

    // R3 R4: youngest visible holder wins, else cache byte
    function automatic logic [255:0] expect_line(int req, int l);
        logic [255:0] v;
        int ra = (req - head_m + NT) % NT;
        for (int b = 0; b < LB; b++) begin
            v[b*8 +: 8] = mem_m[l][b];
            for (int k = 0; k <= ra; k++)
                if (sm[(head_m + k) % NT][l][b]) v[b*8 +: 8] = sv[(head_m + k) % NT][l][b];
        end
        return v;
    endfunction

    task automatic do_read(int s, int l, string tag);
        logic [255:0] e;
        @(negedge clk);
        rd_valid = 1; rd_slot = 2'(s); rd_line = 4'(l);
        e = expect_line(s, l);
        @(negedge clk);
        rd_valid = 0;
        chk(rd_rvalid === 1'b1, "R9 rvalid", {255'd0, rd_rvalid}, 256'd1);
        chk(rd_rdata === e, tag, rd_rdata, e);
    endtask

    task automatic do_store(int s, int l, int w, logic [63:0] d, logic [7:0] be, string tag);
        bit exp_stall;
        @(negedge clk);
        st_valid = 1; st_slot = 2'(s); st_line = 4'(l); st_word = 2'(w); st_data = d; st_be = be;
        exp_stall = (s != head_m) && !line_held(s, l) && lines_held(s) == NE;
        #1;
        chk(st_stall === exp_stall, tag, {255'd0, st_stall}, {255'd0, exp_stall});
        @(negedge clk);
        st_valid = 0;
        if (!exp_stall) begin
            for (int i = 0; i < WB; i++) if (be[i]) begin   // R10 lane placement
                if (s == head_m) begin
                    mem_m[l][w*WB + i] = d[i*8 +: 8];
                    if (sm[s][l][w*WB + i]) sv[s][l][w*WB + i] = d[i*8 +: 8];
                    else if (line_held(s, l)) sv[s][l][w*WB + i] = d[i*8 +: 8];
                end else begin
                    sv[s][l][w*WB + i] = d[i*8 +: 8];
                    sm[s][l][w*WB + i] = 1;
                end
            end
        end
    endtask

    task automatic do_abort(int s);
        @(negedge clk);
        abort_valid = 1; abort_slot = 2'(s);
        @(negedge clk);
        abort_valid = 0;
        if (s != head_m)   // R6 head abort ignored
            for (int l = 0; l < NL; l++) for (int b = 0; b < LB; b++) sm[s][l][b] = 0;
    endtask

    task automatic do_commit();
        int k = 0;
        @(negedge clk);
        cmt_valid = 1;
        @(negedge clk);
        cmt_valid = 0;
        k = 1;
        while (!drain_done && k < 40) begin @(negedge clk); k++; end
        chk(k == NE + 1, "R5 drain cycles", 256'(k), 256'(NE + 1));
        @(negedge clk);
        chk(drain_done === 1'b0, "R5 done pulse", {255'd0, drain_done}, 256'd0);
        for (int l = 0; l < NL; l++) for (int b = 0; b < LB; b++) if (sm[head_m][l][b]) begin
            mem_m[l][b] = sv[head_m][l][b];
            sm[head_m][l][b] = 0;
        end
        head_m = (head_m + 1) % NT;
        chk(head_slot === 2'(head_m), "R5 head advance", 256'(head_slot), 256'(head_m));
    endtask

    task automatic sweep(string tag);
        for (int s = 0; s < NT; s++) for (int l = 0; l < 4; l++) do_read(s, l, tag);
    endtask

    initial begin
        for (int t = 0; t < NT; t++) for (int l = 0; l < NL; l++) for (int b = 0; b < LB; b++) begin
            sv[t][l][b] = 0; sm[t][l][b] = 0;
        end
        for (int l = 0; l < NL; l++) for (int b = 0; b < LB; b++) mem_m[l][b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(head_slot === 2'd0, "R1 head", 256'(head_slot), 256'd0);
        chk(st_stall === 1'b0 && drain_done === 1'b0 && rd_rvalid === 1'b0, "R1 outputs",
            {253'd0, st_stall, drain_done, rd_rvalid}, 256'd0);
        for (int l = 0; l < NL; l++) do_read(0, l, "R1 cache zero");

        // R2 R4: slot 2 writes; slot 1 (older) and slot 0 must not see it, slot 3 does (R3)
        do_store(2, 0, 1, 64'h00000000_0000AA00, 8'h02, "R7 no stall");
        do_read(1, 0, "R4 newer hidden");
        do_read(0, 0, "R2 cache untouched");
        do_read(3, 0, "R3 older visible");
        // R3 priority: slot 3 overrides the same byte, slot 2 still sees its own
        do_store(3, 0, 1, 64'h00000000_0000BB00, 8'h02, "R7 no stall");
        do_read(3, 0, "R3 younger wins");
        do_read(2, 0, "R3 own byte");
        // R10 partial lanes
        do_store(1, 1, 3, 64'h11223344_55667788, 8'h5A, "R10 lanes");
        do_read(1, 1, "R10 lane placement");

        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 40; i++) begin
                lf = nxt(lf);
                do_store(int'(lf[1:0]), int'(lf[3:2]), int'(lf[5:4]), {lf, ~lf}, lf[15:8], "R7 stall flag");
            end
            sweep("R3 merge sweep");
            if (r % 2 == 1) begin
                do_abort((head_m + 2) % NT);
                do_abort(head_m);
                sweep("R6 abort");
            end
            do_commit();
            sweep("R5 after drain");
        end

        // R7: fill a non-head slot with 8 lines, then a 9th
        begin
            int s = (head_m + 1) % NT;
            do_abort(s);
            for (int l = 4; l < 12; l++) do_store(s, l, 0, 64'hC0DE0000_00000000 + 64'(l), 8'hFF, "R7 fill");
            do_store(s, 12, 0, 64'hDEAD, 8'hFF, "R7 stall when full");
            do_read(s, 12, "R7 stalled store dropped");
            do_store(s, 4, 2, 64'hFEED, 8'h03, "R7 held line accepted");
            do_read(s, 4, "R7 held line data");
            do_commit();
            // R8: now head, the same store writes through
            do_store(s, 12, 0, 64'hDEAD, 8'hFF, "R8 head no stall");
            do_read((s + 3) % NT, 12, "R8 write-through");
            for (int l = 0; l < 12; l++) do_store(s, l, 1, 64'(l * 7 + 1), 8'h0F, "R8 head no stall");
            for (int l = 0; l < 12; l++) do_read((s + 1) % NT, l, "R8 cache after head stores");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule